// File: doc/BRIEF.md
# Two-level page table walker

This block resolves a TLB miss by walking a two-level page table held in memory. A miss is offered as a 32-bit virtual address on a valid/ready request port. The walker takes the base of the current first-level table from a root input, reads the first-level entry, and from the frame that entry names reads the second-level entry. It then returns either a physical page number together with the full physical address, ready for the TLB refill, or a page fault that reports which level held an entry that is not resident.

Each table entry carries a 20-bit frame number in bits 31:12 and a resident flag in bit 0. A cleared resident flag means the entry points at secondary storage, and the walk stops at that level with a fault. Only one walk runs at a time. The request port takes a new address only when the walker is idle. The `busy` pin stays high from acceptance until the response has been handed off.

Back-pressure: a request transfers on a cycle where `req_valid` and `req_ready` are both high. The memory read request holds `mem_rd_valid` and `mem_rd_addr` steady until `mem_rd_ready` is seen, and the read data transfers when `mem_rsp_valid` and `mem_rsp_ready` are both high. The walk response holds all of its fields steady until `rsp_ready` is high on a cycle where `rsp_valid` is high. The memory side may stall either phase for any number of cycles.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `rsp_valid` and `mem_rd_valid` are 0.
- R2: The first memory read of a walk uses address root + 4 × vaddr[31:22], where root is the value of `root_base` when the request was accepted.
- R3: The second memory read uses address {first-level entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: When both entries are resident (bit 0 = 1), the response has `rsp_fault` = 0, `rsp_ppn` = second-level entry[31:12] and `rsp_paddr` = {rsp_ppn, vaddr[11:0]}, so the offset passes through unchanged.
- R5: A first-level entry with bit 0 = 0 ends the walk after one memory read, with `rsp_fault` = 1 and `rsp_fault_lvl` = 0.
- R6: A second-level entry with bit 0 = 0 ends the walk after two memory reads, with `rsp_fault` = 1 and `rsp_fault_lvl` = 1.
- R7: From acceptance until the response transfers, `busy` is 1 and `req_ready` is 0. A request offered in that window is not taken and starts no memory read. No memory read is requested while a response is pending.
- R8: A memory read request keeps `mem_rd_valid` high and `mem_rd_addr` unchanged until `mem_rd_ready` is seen.
- R9: A pending response keeps `rsp_valid` high and all of its fields unchanged until `rsp_ready` is seen. After that transfer the walker is idle on the next cycle.
- R10: A change of `root_base` during a walk has no effect on that walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request offered |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte base of the first-level table |
| busy | output | 1 | A walk is in flight |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data available |
| mem_rsp_ready | output | 1 | Walker takes read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | 1 when the page is not resident |
| rsp_fault_lvl | output | 1 | Level of the faulting entry: 0 first, 1 second |
| rsp_ppn | output | 20 | Physical page number (0 on a fault) |
| rsp_paddr | output | 32 | Physical address: page number joined with the offset |

## Verification
The assertions assume a memory that returns exactly one data beat for each accepted read, and never offers data before the read has been accepted. The bench's memory model keeps to this: it serves one read at a time, with set stall lengths for both the accept and the data phases. The assertions also assume that `rsp_ready` and `mem_rd_ready` are free to change. The stimulus stalls both deliberately, to exercise the hold rules. Requests are raised and dropped only on falling clock edges, so acceptance always falls on a known rising edge.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_L1_RD = 3'd1,
    S_L1_WT = 3'd2,
    S_L2_RD = 3'd3,
    S_L2_WT = 3'd4,
    S_DONE  = 3'd5
  } walk_st_e;

  typedef enum logic {
    LVL_ONE = 1'b0,
    LVL_TWO = 1'b1
  } walk_lvl_e;
endpackage

// File: rtl/pgwalk_idx.sv
module pgwalk_idx #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX1_W    = 10,
  parameter int IDX2_W    = 10,
  parameter int ENT_SHIFT = 2
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-1:0]       base_l1,
  input  logic [VA_W-OFF_W-1:0] frame_l1,
  input  logic                  sel_l2,
  output logic [VA_W-1:0]       ent_addr
);
  localparam int FRAME_W = VA_W - OFF_W;

  logic [IDX1_W-1:0] idx1;
  logic [IDX2_W-1:0] idx2;
  logic [VA_W-1:0]   off1, off2, base2;

  assign idx1  = vaddr[VA_W-1 -: IDX1_W];
  assign idx2  = vaddr[OFF_W +: IDX2_W];
  assign off1  = {{(VA_W-IDX1_W){1'b0}}, idx1} << ENT_SHIFT;
  assign off2  = {{(VA_W-IDX2_W){1'b0}}, idx2} << ENT_SHIFT;
  assign base2 = {frame_l1[FRAME_W-1:0], {OFF_W{1'b0}}};

  assign ent_addr = sel_l2 ? (base2 + off2) : (base_l1 + off1);
endmodule

// File: rtl/pgwalk_pte_dec.sv
module pgwalk_pte_dec #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 20,
  parameter int RES_BIT = 0
) (
  input  logic [PTE_W-1:0]   pte,
  output logic [FRAME_W-1:0] frame,
  output logic               resident
);
  assign frame    = pte[PTE_W-1 -: FRAME_W];
  assign resident = pte[RES_BIT];
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [VA_W-1:0]    root_base,
  output logic               req_ready,
  output logic               busy,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [FRAME_W-1:0] pte_frame,
  input  logic               pte_resident,
  output logic               sel_l2,
  output logic [VA_W-1:0]    va_q,
  output logic [VA_W-1:0]    root_q,
  output logic [FRAME_W-1:0] frame1_q,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output walk_lvl_e          rsp_lvl,
  output logic [FRAME_W-1:0] rsp_ppn
);
  walk_st_e st, st_nx;

  assign req_ready     = (st == S_IDLE);
  assign busy          = (st != S_IDLE);
  assign mem_rd_valid  = (st == S_L1_RD) || (st == S_L2_RD);
  assign mem_rsp_ready = (st == S_L1_WT) || (st == S_L2_WT);
  assign sel_l2        = (st == S_L2_RD) || (st == S_L2_WT);
  assign rsp_valid     = (st == S_DONE);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (req_valid) st_nx = S_L1_RD;
      S_L1_RD: if (mem_rd_ready) st_nx = S_L1_WT;
      S_L1_WT: if (mem_rsp_valid) st_nx = pte_resident ? S_L2_RD : S_DONE;
      S_L2_RD: if (mem_rd_ready) st_nx = S_L2_WT;
      S_L2_WT: if (mem_rsp_valid) st_nx = S_DONE;
      S_DONE:  if (rsp_ready) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      st <= st_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q      <= '0;
      root_q    <= '0;
      frame1_q  <= '0;
      rsp_fault <= 1'b0;
      rsp_lvl   <= LVL_ONE;
      rsp_ppn   <= '0;
    end else begin
      if (st == S_IDLE && req_valid) begin
        va_q   <= req_vaddr;
        root_q <= root_base;
      end
      if (st == S_L1_WT && mem_rsp_valid) begin
        frame1_q <= pte_frame;
        if (!pte_resident) begin
          rsp_fault <= 1'b1;
          rsp_lvl   <= LVL_ONE;
          rsp_ppn   <= '0;
        end
      end
      if (st == S_L2_WT && mem_rsp_valid) begin
        rsp_lvl <= LVL_TWO;
        if (pte_resident) begin
          rsp_fault <= 1'b0;
          rsp_ppn   <= pte_frame;
        end else begin
          rsp_fault <= 1'b1;
          rsp_ppn   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX1_W    = 10,
  parameter int IDX2_W    = 10,
  parameter int ENT_SHIFT = 2,
  parameter int RES_BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [VA_W-1:0]       root_base,
  output logic                  busy,
  output logic                  mem_rd_valid,
  input  logic                  mem_rd_ready,
  output logic [VA_W-1:0]       mem_rd_addr,
  input  logic                  mem_rsp_valid,
  output logic                  mem_rsp_ready,
  input  logic [VA_W-1:0]       mem_rsp_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic                  rsp_fault,
  output logic                  rsp_fault_lvl,
  output logic [VA_W-OFF_W-1:0] rsp_ppn,
  output logic [VA_W-1:0]       rsp_paddr
);
  import pgwalk_pkg::*;

  localparam int FRAME_W = VA_W - OFF_W;

  logic [FRAME_W-1:0] pte_frame, frame1_q;
  logic               pte_resident, sel_l2;
  logic [VA_W-1:0]    va_q, root_q;
  walk_lvl_e          rsp_lvl;

  pgwalk_pte_dec #(
    .PTE_W(VA_W), .FRAME_W(FRAME_W), .RES_BIT(RES_BIT)
  ) u_dec (
    .pte(mem_rsp_data), .frame(pte_frame), .resident(pte_resident)
  );

  pgwalk_idx #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX1_W(IDX1_W), .IDX2_W(IDX2_W),
    .ENT_SHIFT(ENT_SHIFT)
  ) u_idx (
    .vaddr(va_q), .base_l1(root_q), .frame_l1(frame1_q),
    .sel_l2(sel_l2), .ent_addr(mem_rd_addr)
  );

  pgwalk_ctrl #(
    .VA_W(VA_W), .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .root_base(root_base),
    .req_ready(req_ready), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .pte_frame(pte_frame), .pte_resident(pte_resident),
    .sel_l2(sel_l2), .va_q(va_q), .root_q(root_q), .frame1_q(frame1_q),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_lvl(rsp_lvl), .rsp_ppn(rsp_ppn)
  );

  assign rsp_fault_lvl = (rsp_lvl == LVL_TWO);
  assign rsp_paddr     = {rsp_ppn, va_q[OFF_W-1:0]};
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int IDX1_W    = 10,
  parameter int ENT_SHIFT = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [VA_W-1:0]       req_vaddr,
  input logic [VA_W-1:0]       root_base,
  input logic                  busy,
  input logic                  mem_rd_valid,
  input logic                  mem_rd_ready,
  input logic [VA_W-1:0]       mem_rd_addr,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic                  rsp_fault,
  input logic                  rsp_fault_lvl,
  input logic [VA_W-OFF_W-1:0] rsp_ppn,
  input logic [VA_W-1:0]       rsp_paddr
);
  logic [VA_W-1:0] va_c, root_c, l1_exp;
  logic [1:0]      rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_c   <= '0;
      root_c <= '0;
      rd_n   <= '0;
    end else if (req_valid && req_ready) begin
      va_c   <= req_vaddr;
      root_c <= root_base;
      rd_n   <= '0;
    end else if (mem_rd_valid && mem_rd_ready && rd_n != 2'd3) begin
      rd_n <= rd_n + 2'd1;
    end
  end

  assign l1_exp = root_c + ({{(VA_W-IDX1_W){1'b0}}, va_c[VA_W-1 -: IDX1_W]} << ENT_SHIFT);

  p_l1_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && rd_n == 2'd0) |-> (mem_rd_addr == l1_exp));

  p_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_c[OFF_W-1:0] && rd_n == 2'd2));

  p_l1_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !rsp_fault_lvl) |-> (rd_n == 2'd1 && rsp_ppn == '0));

  p_l2_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_fault_lvl) |-> (rd_n == 2'd2));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  p_no_rd_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_valid);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable({rsp_fault, rsp_fault_lvl, rsp_ppn, rsp_paddr})));

  p_idle_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!busy && req_ready));
endmodule

bind pgwalk_top pgwalk_chk #(
  .VA_W(VA_W), .OFF_W(OFF_W), .IDX1_W(IDX1_W), .ENT_SHIFT(ENT_SHIFT)
) u_pgwalk_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
  .root_base(root_base), .busy(busy),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
  .rsp_fault_lvl(rsp_fault_lvl), .rsp_ppn(rsp_ppn), .rsp_paddr(rsp_paddr)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr, root_base;
  logic        busy;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready, rsp_fault, rsp_fault_lvl;
  logic [19:0] rsp_ppn;
  logic [31:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  int hold_err = 0;
  int lat_a = 0;
  int lat_b = 0;
  logic [31:0] rd_log [0:7];
  logic [31:0] mem_m [logic [31:0]];
  bit done = 0;

  always #5 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .root_base(root_base), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault),
    .rsp_fault_lvl(rsp_fault_lvl), .rsp_ppn(rsp_ppn), .rsp_paddr(rsp_paddr)
  );

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (mem_m.exists(a)) return mem_m[a];
    return 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one read at a time, stalls on both phases
  initial begin
    logic [31:0] a;
    mem_rd_ready  = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd_valid) begin
        a = mem_rd_addr;
        for (int i = 0; i < lat_a; i++) begin
          @(negedge clk);
          if (!mem_rd_valid || mem_rd_addr !== a) hold_err++;
        end
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
        rd_log[rd_cnt % 8] = a;
        rd_cnt++;
        for (int i = 0; i < lat_b; i++) @(negedge clk);
        mem_rsp_data  = rd_word(a);
        mem_rsp_valid = 1'b1;
        while (!mem_rsp_ready) @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // one walk: accept, wait for result, stall the result, release
  task automatic walk(input logic [31:0] va, input int hold,
                      output logic f, output logic lv,
                      output logic [19:0] ppn, output logic [31:0] pa,
                      output int nrd, output int base);
    int t;
    logic [31:0] snap;
    base = rd_cnt;
    @(negedge clk);
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    snap = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R9 response held", {31'b0, rsp_valid}, 32'h1);
      check("R9 paddr stable", rsp_paddr, snap);
    end
    f = rsp_fault; lv = rsp_fault_lvl; ppn = rsp_ppn; pa = rsp_paddr;
    nrd = rd_cnt - base;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 idle after handoff", {30'b0, busy, req_ready}, 32'h1);
  endtask

  task automatic t_reset;
    check("R1 req_ready", {31'b0, req_ready}, 32'h1);
    check("R1 busy", {31'b0, busy}, 32'h0);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 mem_rd_valid", {31'b0, mem_rd_valid}, 32'h0);
  endtask

  task automatic t_hit;
    logic f, lv; logic [19:0] ppn; logic [31:0] pa; int n, b;
    lat_a = 0; lat_b = 0;
    walk(32'h0040_3ABC, 2, f, lv, ppn, pa, n, b);
    check("R2 l1 address", rd_log[b % 8], 32'h0001_0004);
    check("R3 l2 address", rd_log[(b+1) % 8], 32'h0002_000C);
    check("R4 no fault", {31'b0, f}, 32'h0);
    check("R4 ppn", {12'b0, ppn}, 32'h0001_2345);
    check("R4 paddr", pa, 32'h1234_5ABC);
  endtask

  task automatic t_top_corner;
    logic f, lv; logic [19:0] ppn; logic [31:0] pa; int n, b;
    lat_a = 3; lat_b = 2; hold_err = 0;
    walk(32'hFFFF_F123, 0, f, lv, ppn, pa, n, b);
    check("R2 l1 address max index", rd_log[b % 8], 32'h0001_0FFC);
    check("R3 l2 address max index", rd_log[(b+1) % 8], 32'h0003_0FFC);
    check("R4 paddr max index", pa, 32'hABCD_E123);
    check("R8 read request held", hold_err, 0);
  endtask

  task automatic t_l1_fault;
    logic f, lv; logic [19:0] ppn; logic [31:0] pa; int n, b;
    lat_a = 1; lat_b = 1;
    walk(32'h0080_0000, 1, f, lv, ppn, pa, n, b);
    check("R5 fault", {31'b0, f}, 32'h1);
    check("R5 level", {31'b0, lv}, 32'h0);
    check("R5 one read", n, 1);
    check("R2 l1 address fault", rd_log[b % 8], 32'h0001_0008);
  endtask

  task automatic t_l2_fault;
    logic f, lv; logic [19:0] ppn; logic [31:0] pa; int n, b;
    lat_a = 0; lat_b = 3;
    walk(32'h0040_4000, 1, f, lv, ppn, pa, n, b);
    check("R6 fault", {31'b0, f}, 32'h1);
    check("R6 level", {31'b0, lv}, 32'h1);
    check("R6 two reads", n, 2);
    check("R3 l2 address fault", rd_log[(b+1) % 8], 32'h0002_0010);
  endtask

  task automatic t_busy_block;
    int b, t;
    lat_a = 2; lat_b = 2;
    b = rd_cnt;
    @(negedge clk);
    req_vaddr = 32'h0040_3ABC; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h0080_0000;
    check("R7 busy after accept", {30'b0, busy, req_ready}, 32'h2);
    t = 0;
    while (!rsp_valid && t < 200) begin
      @(negedge clk); t++;
      if (!rsp_valid) check("R7 not ready while busy", {31'b0, req_ready}, 32'h0);
    end
    check("R7 response pending, no read", {31'b0, mem_rd_valid}, 32'h0);
    req_valid = 1'b0;
    check("R4 paddr under busy test", rsp_paddr, 32'h1234_5ABC);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 blocked request started no read", rd_cnt - b, 2);
    check("R7 idle", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_root_change;
    logic f, lv; logic [19:0] ppn; logic [31:0] pa; int t, b;
    lat_a = 1; lat_b = 1;
    b = rd_cnt;
    @(negedge clk);
    req_vaddr = 32'h0040_3ABC; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    root_base = 32'h0005_0000;
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    check("R10 l1 address uses old root", rd_log[b % 8], 32'h0001_0004);
    check("R10 paddr unaffected", rsp_paddr, 32'h1234_5ABC);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    walk(32'h0000_0111, 0, f, lv, ppn, pa, t, b);
    check("R10 new root used", rd_log[b % 8], 32'h0005_0000);
    check("R4 paddr new root", pa, 32'h0777_7111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    mem_m[32'h0001_0004] = 32'h0002_0001;
    mem_m[32'h0002_000C] = 32'h1234_5001;
    mem_m[32'h0001_0FFC] = 32'h0003_0001;
    mem_m[32'h0003_0FFC] = 32'hABCD_E001;
    mem_m[32'h0001_0008] = 32'h0004_0000;
    mem_m[32'h0002_0010] = 32'h5555_5000;
    mem_m[32'h0005_0000] = 32'h0006_0001;
    mem_m[32'h0006_0000] = 32'h0777_7001;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = 32'h0;
    root_base = 32'h0001_0000; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_top_corner();
    t_l1_fault();
    t_l2_fault();
    t_busy_block();
    t_root_change();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule